// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store pipeline and an 8-byte-wide memory port. It takes one memory request at a time: a byte address, an access size of 1, 2 or 4 bytes, a multiple-word flag, a string flag and an endianness mode bit. It decides whether the request can be served by one aligned memory access, needs two aligned accesses, or must raise an alignment exception instead.

Served requests leave as a sequence of sub-accesses on a valid/ready port. Each sub-access carries the 8-byte-aligned unit address, a byte-enable mask that marks only the requested bytes inside that unit, and a flag on the final sub-access. A request that spans two units goes out as two sub-accesses, with the lower unit first. A request that must trap produces a one-cycle exception pulse and touches no memory. The block takes a new request only after the final sub-access of the previous one has been accepted.

Top module: `misal_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_valid` and `exc_pulse` are 0.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. A naturally aligned request gives one sub-access. Its `mem_addr` is the request address with bits [2:0] cleared, its `mem_be` has bit i set for each requested byte at lane (address mod 8) = i, and `mem_last` is 1.
- R3: A request that is not naturally aligned but lies inside one 8-byte unit gives one sub-access whose byte enables are shifted to the byte offset, with `mem_last` set to 1.
- R4: A request whose bytes span two 8-byte units gives exactly two sub-accesses. The first goes to the lower unit, carrying the enables for the bytes in that unit, with `mem_last` = 0. The second goes to the lower unit + 8, carrying the remaining enables, with `mem_last` = 1. Address arithmetic wraps modulo 2^AW.
- R5: A multiple-word request (`req_mw` = 1) is always a 4-byte access and ignores `req_size`. If its address is not a multiple of 4, it raises the exception.
- R6: In little-endian mode (`req_le` = 1), any request with `req_mw` or `req_str` set raises the exception, whatever its alignment.
- R7: When a request raises the exception, `exc_pulse` is 1 for exactly the one cycle after acceptance. No sub-access is issued for that request, and `req_ready` is 0 during the pulse.
- R8: Size code 3 on a request that is not multiple-word raises the exception.
- R9: Apart from R6, a little-endian request produces exactly the same sub-accesses as the same request in big-endian mode.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, the outputs `mem_valid`, `mem_addr`, `mem_be` and `mem_last` hold steady. `req_ready` stays 0 from the acceptance of a request until its final sub-access has been accepted.
- R11: A string request in big-endian mode is handled like a plain access of its size, and is split when it spans two units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Byte address of the request |
| req_size | input | 2 | Size code (0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = invalid) |
| req_mw | input | 1 | Multiple-word request |
| req_str | input | 1 | String request |
| req_le | input | 1 | Little-endian mode |
| mem_valid | output | 1 | Sub-access offered |
| mem_ready | input | 1 | Memory port accepts the sub-access |
| mem_addr | output | AW | 8-byte-aligned unit address |
| mem_be | output | LANES | Byte enables within the unit |
| mem_last | output | 1 | Final sub-access of the request |
| exc_pulse | output | 1 | One-cycle alignment exception |

## Verification
The assertions assume that the memory side obeys valid/ready. They also assume that `req_valid` is only seen as a handshake while `req_ready` is 1, so a request offered during a busy or exception cycle is simply not taken. The bench offers each request for a single cycle, and only when it has seen `req_ready` high. It varies `mem_ready` at random to stall sub-accesses, so the hold rule is exercised for both halves of a split. The random addresses cover every lane offset in both endian modes, and directed cases cover the top of the address space.

// File: rtl/misal_pkg.sv
package misal_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;
endpackage

// File: rtl/misal_classify.sv
module misal_classify #(
  parameter int AW    = 32,
  parameter int LANES = 8
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  input  logic             mw,
  input  logic             str,
  input  logic             le,
  output logic             exc,
  output logic             split,
  output logic [AW-1:0]    lo_addr,
  output logic [AW-1:0]    hi_addr,
  output logic [LANES-1:0] be_lo,
  output logic [LANES-1:0] be_hi
);
  import misal_pkg::*;
  localparam int LW = $clog2(LANES);
  localparam int SW = 2 * LANES;

  logic [SW-1:0] mask;
  logic [SW-1:0] span;
  logic [LW-1:0] offset;

  assign offset = addr[LW-1:0];

  // Byte mask for the access width, before it is placed at the lane offset
  always_comb begin
    if (mw) begin
      mask = SW'(4'hF);
    end else begin
      case (size_e'(size))
        SZ_BYTE: mask = SW'(4'h1);
        SZ_HALF: mask = SW'(4'h3);
        default: mask = SW'(4'hF);
      endcase
    end
  end

  assign span  = mask << offset;
  assign be_lo = span[LANES-1:0];
  assign be_hi = span[SW-1:LANES];
  assign split = |be_hi;

  assign lo_addr = {addr[AW-1:LW], {LW{1'b0}}};
  assign hi_addr = lo_addr + AW'(LANES);

  // Trap conditions: invalid size, block ops in little-endian, unaligned multiple-word
  always_comb begin
    exc = 1'b0;
    if (!mw && size_e'(size) == SZ_BAD) exc = 1'b1;
    if ((mw || str) && le)              exc = 1'b1;
    if (mw && addr[1:0] != 2'b00)       exc = 1'b1;
  end
endmodule

// File: rtl/misal_seq.sv
module misal_seq #(
  parameter int AW    = 32,
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             c_exc,
  input  logic             c_split,
  input  logic [AW-1:0]    c_lo_addr,
  input  logic [AW-1:0]    c_hi_addr,
  input  logic [LANES-1:0] c_be_lo,
  input  logic [LANES-1:0] c_be_hi,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] mem_be,
  output logic             mem_last,
  output logic             exc_pulse
);
  localparam int LW = $clog2(LANES);

  logic             busy;
  logic [AW-1:0]    hi_addr_q;
  logic [LANES-1:0] hi_be_q;
  logic             take;

  assign req_ready = ~busy & ~exc_pulse;
  assign take      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_last  <= 1'b0;
      exc_pulse <= 1'b0;
      hi_addr_q <= '0;
      hi_be_q   <= '0;
    end else begin
      exc_pulse <= 1'b0;
      if (take) begin
        if (c_exc) begin
          exc_pulse <= 1'b1;
        end else begin
          busy      <= 1'b1;
          mem_valid <= 1'b1;
          mem_addr  <= c_lo_addr;
          mem_be    <= c_be_lo;
          mem_last  <= ~c_split;
          hi_addr_q <= c_hi_addr;
          hi_be_q   <= c_be_hi;
        end
      end else if (mem_valid && mem_ready) begin
        if (!mem_last) begin
          mem_addr <= hi_addr_q;
          mem_be   <= hi_be_q;
          mem_last <= 1'b1;
        end else begin
          mem_valid <= 1'b0;
          busy      <= 1'b0;
        end
      end
    end
  end

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_last));

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    exc_pulse |=> !exc_pulse);

  a_r7_no_access: assert property (@(posedge clk) disable iff (rst)
    exc_pulse |-> !mem_valid);

  a_r4_second_is_last: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && !mem_last |=> mem_valid && mem_last);

  a_r2_enables_present: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_be != '0);

  a_r2_unit_address: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[LW-1:0] == '0);
endmodule

// File: rtl/misal_splitter.sv
module misal_splitter #(
  parameter int AW    = 32,
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_mw,
  input  logic             req_str,
  input  logic             req_le,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] mem_be,
  output logic             mem_last,
  output logic             exc_pulse
);
  logic             c_exc;
  logic             c_split;
  logic [AW-1:0]    c_lo_addr;
  logic [AW-1:0]    c_hi_addr;
  logic [LANES-1:0] c_be_lo;
  logic [LANES-1:0] c_be_hi;

  misal_classify #(.AW(AW), .LANES(LANES)) u_cls (
    .addr    (req_addr),
    .size    (req_size),
    .mw      (req_mw),
    .str     (req_str),
    .le      (req_le),
    .exc     (c_exc),
    .split   (c_split),
    .lo_addr (c_lo_addr),
    .hi_addr (c_hi_addr),
    .be_lo   (c_be_lo),
    .be_hi   (c_be_hi)
  );

  misal_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .c_exc     (c_exc),
    .c_split   (c_split),
    .c_lo_addr (c_lo_addr),
    .c_hi_addr (c_hi_addr),
    .c_be_lo   (c_be_lo),
    .c_be_hi   (c_be_hi),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_last  (mem_last),
    .exc_pulse (exc_pulse)
  );
endmodule

// File: tb/sim_misal_splitter.sv
module sim_misal_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_mw = 1'b0;
  logic        req_str = 1'b0;
  logic        req_le = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic        mem_last;
  logic        exc_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  misal_splitter #(.AW(32), .LANES(8)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_mw(req_mw), .req_str(req_str),
    .req_le(req_le), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_last(mem_last), .exc_pulse(exc_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements, walking byte by byte
  function automatic void model(input logic [31:0] a, input logic [1:0] sz,
                                input logic mw, input logic str, input logic le,
                                output bit exc, output int n,
                                output logic [31:0] ad0, output logic [31:0] ad1,
                                output logic [7:0] b0, output logic [7:0] b1);
    int nb;
    logic [31:0] ba;
    nb  = mw ? 4 : (sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4));
    exc = (!mw && sz == 2'd3) || ((mw || str) && le) || (mw && a[1:0] != 2'b00);
    ad0 = a & ~32'h7;
    ad1 = ad0 + 32'd8;
    b0  = '0;
    b1  = '0;
    for (int k = 0; k < nb; k++) begin
      ba = a + 32'(k);
      if ((ba & ~32'h7) == ad0) b0[ba[2:0]] = 1'b1;
      else                      b1[ba[2:0]] = 1'b1;
    end
    n = (b1 != 8'h0) ? 2 : 1;
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic mw,
                         input logic str, input logic le, input string tag);
    bit exc;
    int n;
    logic [31:0] ad0, ad1, ea;
    logic [7:0] b0, b1, eb;
    bit stall;
    model(a, sz, mw, str, le, exc, n, ad0, ad1, b0, b1);
    chk(req_ready === 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
    req_addr = a; req_size = sz; req_mw = mw; req_str = str; req_le = le;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exc) begin
      chk(exc_pulse === 1'b1 && mem_valid === 1'b0 && req_ready === 1'b0,
          {tag, " R7 exception pulse"}, {61'd0, exc_pulse, mem_valid, req_ready}, 64'h4);
      @(negedge clk);
      chk(exc_pulse === 1'b0 && mem_valid === 1'b0 && req_ready === 1'b1,
          {tag, " R7 pulse ends, no access"}, {61'd0, exc_pulse, mem_valid, req_ready}, 64'h1);
    end else begin
      for (int i = 0; i < n; i++) begin
        ea = (i == 0) ? ad0 : ad1;
        eb = (i == 0) ? b0 : b1;
        do begin
          stall = ($urandom % 3) == 0;
          mem_ready = !stall;
          chk(mem_valid === 1'b1 && mem_addr === ea && mem_be === eb &&
              mem_last === (i == n - 1) && req_ready === 1'b0,
              {tag, " R2 R3 R4 R10 sub-access"},
              {mem_valid, mem_last, req_ready, 13'd0, mem_be, 8'd0, mem_addr},
              {1'b1, 1'(i == n - 1), 1'b0, 13'd0, eb, 8'd0, ea});
          @(negedge clk);
        end while (stall);
      end
      mem_ready = 1'b0;
      chk(mem_valid === 1'b0 && req_ready === 1'b1, {tag, " R10 done, ready again"},
          {62'd0, mem_valid, req_ready}, 64'h1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_valid === 1'b0 && exc_pulse === 1'b0, "R1 reset state",
        {61'd0, req_ready, mem_valid, exc_pulse}, 64'h4);

    run_req(32'h0000_0100, 2'd2, 1'b0, 1'b0, 1'b0, "R2 aligned word");
    run_req(32'h0000_0107, 2'd0, 1'b0, 1'b0, 1'b0, "R2 byte at lane 7");
    run_req(32'h0000_0102, 2'd2, 1'b0, 1'b0, 1'b0, "R3 misaligned word inside unit");
    run_req(32'h0000_0107, 2'd1, 1'b0, 1'b0, 1'b0, "R4 half crossing");
    run_req(32'h0000_0105, 2'd2, 1'b0, 1'b0, 1'b0, "R4 word crossing");
    run_req(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b0, 1'b0, "R4 wrap at top");
    run_req(32'h0000_0204, 2'd0, 1'b1, 1'b0, 1'b0, "R5 multiple-word aligned");
    run_req(32'h0000_0206, 2'd2, 1'b1, 1'b0, 1'b0, "R5 multiple-word unaligned");
    run_req(32'h0000_0200, 2'd2, 1'b1, 1'b0, 1'b1, "R6 multiple-word little-endian");
    run_req(32'h0000_0301, 2'd0, 1'b0, 1'b1, 1'b1, "R6 string little-endian");
    run_req(32'h0000_0040, 2'd3, 1'b0, 1'b0, 1'b0, "R8 size code 3");
    run_req(32'h0000_010F, 2'd1, 1'b0, 1'b0, 1'b1, "R9 little-endian half crossing");
    run_req(32'h0000_0007, 2'd2, 1'b0, 1'b1, 1'b0, "R11 string big-endian split");

    for (int t = 0; t < 400; t++) begin
      logic [31:0] ra;
      logic [1:0]  rs;
      logic        rm, rstr, rl;
      ra   = $urandom;
      rs   = 2'($urandom % 4);
      rm   = ($urandom % 8) == 0;
      rstr = ($urandom % 8) == 0;
      rl   = 1'($urandom % 2);
      run_req(ra, rs, rm, rstr, rl, "R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule